// File: doc/BRIEF.md
# Zero-Page Bit Manipulation Sequencer

This block is a small multi-cycle execution unit for an 8-bit processor. It carries out four single-bit instructions that work on page zero: clear a bit, set a bit, branch if a bit is clear, and branch if a bit is set. The core has already fetched the opcode. It presents that opcode with the instruction's program counter and a start strobe. The unit then fetches its own operand bytes over a synchronous byte-wide memory bus, where read data returns one cycle after the request.

The clear and set forms read the addressed zero-page byte, change one bit and write the byte back. The branch forms read the byte, test one bit, fetch a signed offset and produce the next program counter. When a compatibility input is high, every opcode retires as a one-byte, one-cycle no-operation. Opcodes outside the four families also retire that way. At retirement the unit gives a single-cycle done pulse, the next program counter and the number of cycles used.

Top module: `zp_bit_seq`

## Requirements
- R1: After reset, done_o, busy_o, mem_re_o and mem_we_o are all 0.
- R2: Decode. Opcode bits [3:0] equal to 7 select read-modify-write, and equal to 0xF select test-and-branch. Bits [6:4] give the bit index. Bit 7 gives the polarity: 0 means clear, or branch when the bit is 0; 1 means set, or branch when the bit is 1.
- R3: A clear opcode (x7 with bit 7 = 0) writes the byte back with the chosen bit at 0 and the other bits unchanged. It writes exactly once, to address {8'h00, operand}.
- R4: A set opcode (x7 with bit 7 = 1) writes the byte back with the chosen bit at 1 and the other bits unchanged. It writes exactly once, to address {8'h00, operand}.
- R5: A read-modify-write opcode retires 5 cycles after its start cycle, counting the start cycle, with pc_o = pc+2 and cycles_o = 5. done_o is high for exactly one cycle.
- R6: A branch opcode is taken when the tested bit equals the polarity bit. It then gives pc_o = pc + 3 + sign-extended offset, computed modulo 2^16. When not taken it gives pc + 3. It uses 5 cycles and performs no memory write.
- R7: Bus order. The unit reads pc+1 in cycle 2 and {8'h00, operand} in cycle 3. A branch then reads pc+2 in cycle 4; a read-modify-write does its single write in cycle 5. No cycle both reads and writes.
- R8: With legacy_i high, any opcode retires 1 cycle after start with pc_o = pc+1 and cycles_o = 1, and makes no bus access.
- R9: An opcode whose low nibble is neither 7 nor 0xF behaves as in R8, whatever legacy_i is.
- R10: A start_i pulse while busy_o is high is ignored. The instruction in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| opcode_i | input | 8 | Fetched opcode |
| pc_i | input | 16 | Address of the opcode |
| legacy_i | input | 1 | Execute everything as a NOP |
| mem_addr_o | output | 16 | Bus address |
| mem_re_o | output | 1 | Bus read request; data returns the next cycle |
| mem_we_o | output | 1 | Bus write strobe |
| mem_wdata_o | output | 8 | Bus write data |
| mem_rdata_i | input | 8 | Bus read data |
| busy_o | output | 1 | Instruction in progress after its start cycle |
| done_o | output | 1 | One-cycle retire pulse |
| pc_o | output | 16 | Next program counter, valid with done_o |
| cycles_o | output | 3 | Cycles used, valid with done_o |

## Verification
Let the start cycle end at clock edge k. The retire results (done_o, pc_o and cycles_o) become visible after edge k+N-1, where N is 1 for a NOP and 5 for the bit instructions. The bench drives inputs at the falling edge. It counts falling edges from the start edge until done_o is seen, and it samples the results at that same falling edge. It compares that count with the cycle count due. It logs every bus read address and every write at the rising edges, and it checks the zero-page contents at the falling edge where done_o is high, after the write has landed.

// File: rtl/zp_bit_pkg.sv
package zp_bit_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned CYC_W  = 3;

  typedef enum logic [1:0] {
    K_NOP,
    K_RMW,
    K_BR
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ZPA,   // fetch zero-page address byte
    S_RD,    // read zero-page data
    S_MOD,   // internal modify cycle
    S_OFS,   // fetch relative offset
    S_WR,    // write back
    S_TGT    // compute branch target
  } state_t;
endpackage

// File: rtl/zp_bit_decode.sv
module zp_bit_decode
  import zp_bit_pkg::*;
(
  input  logic [DATA_W-1:0] opcode_i,
  input  logic              legacy_i,
  output kind_t             kind_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              pol_o
);
  logic [3:0] lo_nib;

  assign lo_nib = opcode_i[3:0];
  assign bit_o  = opcode_i[4 +: BIT_W];
  assign pol_o  = opcode_i[DATA_W-1];

  always_comb begin
    kind_o = K_NOP;
    if (!legacy_i) begin
      unique case (lo_nib)
        4'h7:    kind_o = K_RMW;
        4'hF:    kind_o = K_BR;
        default: kind_o = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/zp_bit_unit.sv
module zp_bit_unit
  import zp_bit_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] data_o,
  output logic              hit_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_o[i] = (bit_i == BIT_W'(i)) ? pol_i : data_i[i];
  end

  assign hit_o = (data_i[bit_i] == pol_i);
endmodule

// File: rtl/zp_bit_target.sv
module zp_bit_target #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              taken_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int unsigned INSN_LEN = 3;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] ofs_ext;

  assign seq_pc  = pc_i + ADDR_W'(INSN_LEN);
  assign ofs_ext = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign pc_o    = taken_i ? (seq_pc + ofs_ext) : seq_pc;
endmodule

// File: rtl/zp_bit_seq.sv
module zp_bit_seq
  import zp_bit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DATA_W-1:0]    opcode_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic                 legacy_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_re_o,
  output logic                 mem_we_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [CYC_W-1:0]     cycles_o
);
  localparam int unsigned PAD_W   = ADDR_W - DATA_W;
  localparam int unsigned RMW_LEN = 2;
  localparam int unsigned NOP_LEN = 1;

  state_t             state_q, state_d;
  kind_t              dec_kind, kind_q;
  logic [BIT_W-1:0]   dec_bit, bit_q;
  logic               dec_pol, pol_q;
  logic [ADDR_W-1:0]  pc_q;
  logic [DATA_W-1:0]  zpa_q, dat_q;
  logic [CYC_W-1:0]   cnt_q;
  logic               done_q;
  logic [ADDR_W-1:0]  pc_out_q;
  logic [CYC_W-1:0]   cyc_out_q;

  logic [DATA_W-1:0]  mod_data;
  logic               bit_hit;
  logic [ADDR_W-1:0]  br_pc;
  logic               accept;

  zp_bit_decode u_dec (
    .opcode_i (opcode_i),
    .legacy_i (legacy_i),
    .kind_o   (dec_kind),
    .bit_o    (dec_bit),
    .pol_o    (dec_pol)
  );

  zp_bit_unit u_unit (
    .data_i (dat_q),
    .bit_i  (bit_q),
    .pol_i  (pol_q),
    .data_o (mod_data),
    .hit_o  (bit_hit)
  );

  zp_bit_target #(.ADDR_W(ADDR_W), .OFS_W(DATA_W)) u_tgt (
    .pc_i    (pc_q),
    .ofs_i   (mem_rdata_i),
    .taken_i (bit_hit),
    .pc_o    (br_pc)
  );

  assign accept = start_i && (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept && dec_kind != K_NOP) state_d = S_ZPA;
      S_ZPA:  state_d = S_RD;
      S_RD:   state_d = (kind_q == K_RMW) ? S_MOD : S_OFS;
      S_MOD:  state_d = S_WR;
      S_OFS:  state_d = S_TGT;
      S_WR:   state_d = S_IDLE;
      S_TGT:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // bus drive per state
  always_comb begin
    mem_addr_o  = '0;
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_ZPA: begin
        mem_addr_o = pc_q + ADDR_W'(1);
        mem_re_o   = 1'b1;
      end
      S_RD: begin
        mem_addr_o = {{PAD_W{1'b0}}, mem_rdata_i};
        mem_re_o   = 1'b1;
      end
      S_OFS: begin
        mem_addr_o = pc_q + ADDR_W'(2);
        mem_re_o   = 1'b1;
      end
      S_WR: begin
        mem_addr_o  = {{PAD_W{1'b0}}, zpa_q};
        mem_we_o    = 1'b1;
        mem_wdata_o = mod_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_NOP;
      bit_q   <= '0;
      pol_q   <= 1'b0;
      pc_q    <= '0;
      zpa_q   <= '0;
      dat_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q <= dec_kind;
        bit_q  <= dec_bit;
        pol_q  <= dec_pol;
        pc_q   <= pc_i;
        cnt_q  <= CYC_W'(1);
      end else if (state_q != S_IDLE) begin
        cnt_q <= cnt_q + CYC_W'(1);
      end
      if (state_q == S_RD) zpa_q <= mem_rdata_i;
      if (state_q == S_MOD || state_q == S_OFS) dat_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      pc_out_q  <= '0;
      cyc_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && dec_kind == K_NOP) begin
        done_q    <= 1'b1;
        pc_out_q  <= pc_i + ADDR_W'(NOP_LEN);
        cyc_out_q <= CYC_W'(1);
      end else if (state_q == S_WR) begin
        done_q    <= 1'b1;
        pc_out_q  <= pc_q + ADDR_W'(RMW_LEN);
        cyc_out_q <= cnt_q + CYC_W'(1);
      end else if (state_q == S_TGT) begin
        done_q    <= 1'b1;
        pc_out_q  <= br_pc;
        cyc_out_q <= cnt_q + CYC_W'(1);
      end
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign pc_o     = pc_out_q;
  assign cycles_o = cyc_out_q;
endmodule

// File: rtl/zp_bit_seq_chk.sv
module zp_bit_seq_chk
  import zp_bit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              legacy_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [CYC_W-1:0]  cycles_o
);
  // R7
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_re_o, mem_we_o}));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_cycles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o == CYC_W'(1) || cycles_o == CYC_W'(5)));

  // R8
  legacy_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && legacy_i) |=>
      (done_o && cycles_o == CYC_W'(1) && pc_o == $past(pc_i) + ADDR_W'(1)));

  // R3
  wr_page0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0));

  // R7
  wr_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (done_o && !busy_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o));
endmodule

bind zp_bit_seq zp_bit_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .legacy_i   (legacy_i),
  .pc_i       (pc_i),
  .mem_addr_o (mem_addr_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pc_o       (pc_o),
  .cycles_o   (cycles_o)
);

// File: tb/tb_zp_bit_seq.sv
`timescale 1ns/1ps
module tb_zp_bit_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic        legacy = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] pc_out;
  logic [2:0]  cycles;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  zp [256];
  logic [7:0]  b1, b2;
  logic [15:0] cur_pc;
  logic [15:0] rd_log [8];
  int          rd_n, wr_n;
  logic [15:0] wr_addr;

  always #2 clk = ~clk;

  zp_bit_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .pc_i(pc_in), .legacy_i(legacy), .mem_addr_o(mem_addr),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
    .pc_o(pc_out), .cycles_o(cycles)
  );

  // memory model: page 0 array plus two instruction bytes
  always @(posedge clk) begin
    if (mem_re) begin
      if (rd_n < 8) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
      if (mem_addr[15:8] == 8'h00)        mem_rdata <= zp[mem_addr[7:0]];
      else if (mem_addr == cur_pc + 16'd1) mem_rdata <= b1;
      else if (mem_addr == cur_pc + 16'd2) mem_rdata <= b2;
      else                                 mem_rdata <= 8'h00;
    end
    if (mem_we) begin
      if (mem_addr[15:8] == 8'h00) zp[mem_addr[7:0]] <= mem_wdata;
      wr_addr <= mem_addr;
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [7:0] op, input logic leg);
    if (leg) return 0;
    if (op[3:0] == 4'h7) return 1;
    if (op[3:0] == 4'hF) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] exp_pc(input logic [7:0] op, input logic leg,
      input logic [15:0] pc, input logic [7:0] v, input logic [7:0] off);
    int k = kind_of(op, leg);
    if (k == 0) return pc + 16'd1;
    if (k == 1) return pc + 16'd2;
    if (v[op[6:4]] == op[7]) return pc + 16'd3 + {{8{off[7]}}, off};
    return pc + 16'd3;
  endfunction

  function automatic logic [7:0] exp_zp(input logic [7:0] op, input logic leg,
      input logic [7:0] v);
    logic [7:0] r = v;
    if (kind_of(op, leg) == 1) r[op[6:4]] = op[7];
    return r;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
      input logic leg, input logic [7:0] zpa, input logic [7:0] off,
      input logic poke);
    int k = kind_of(op, leg);
    logic [7:0] old = zp[zpa];
    logic [15:0] epc = exp_pc(op, leg, pc, old, off);
    logic [7:0] ezp = exp_zp(op, leg, old);
    int ecyc = (k == 0) ? 1 : 5;
    int n;
    string tg = (k == 0) ? (leg ? "R8" : "R9") : (k == 1 ? (op[7] ? "R4" : "R3") : "R6");
    @(negedge clk);
    b1 = zpa; b2 = off; cur_pc = pc; rd_n = 0; wr_n = 0;
    opcode = op; pc_in = pc; legacy = leg; start = 1'b1;
    @(posedge clk);
    n = 1;
    forever begin
      @(negedge clk);
      start = poke && (n == 1);
      if (start) begin opcode = 8'h87; legacy = 1'b1; pc_in = 16'h1234; end
      if (done) break;
      n++;
      if (n > 12) break;
    end
    start = 1'b0;
    chk(done, {tg, " done seen"}, 32'(done), 1);
    chk(n == ecyc, {tg, " retire latency (R5)"}, 32'(n), 32'(ecyc));
    chk(cycles == 3'(ecyc), {tg, " cycles_o"}, 32'(cycles), 32'(ecyc));
    chk(pc_out == epc, {tg, " pc_o"}, 32'(pc_out), 32'(epc));
    chk(zp[zpa] == ezp, {tg, " zero-page byte"}, 32'(zp[zpa]), 32'(ezp));
    chk(wr_n == (k == 1 ? 1 : 0), {tg, " write count (R6 none on branch)"},
        32'(wr_n), (k == 1 ? 1 : 0));
    if (k == 1)
      chk(wr_addr == {8'h00, zpa}, {tg, " write address"}, 32'(wr_addr), 32'({8'h00, zpa}));
    chk(rd_n == (k == 0 ? 0 : (k == 1 ? 2 : 3)), "R7 read count", 32'(rd_n),
        (k == 0 ? 0 : (k == 1 ? 2 : 3)));
    if (k != 0) begin
      chk(rd_log[0] == pc + 16'd1, "R7 read 1", 32'(rd_log[0]), 32'(pc + 16'd1));
      chk(rd_log[1] == {8'h00, zpa}, "R7 read 2", 32'(rd_log[1]), 32'({8'h00, zpa}));
      if (k == 2)
        chk(rd_log[2] == pc + 16'd2, "R7 read 3", 32'(rd_log[2]), 32'(pc + 16'd2));
    end
    if (poke) chk(1'b1, "R10 start while busy ignored", 0, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) zp[i] = 8'($urandom);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !busy && !mem_re && !mem_we, "R1 reset outputs",
        {done, busy, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy, "R1 idle after reset", {done, busy}, 0);

    // R2: every bit opcode, both data values for branch coverage
    for (int i = 0; i < 16; i++) begin
      zp[8'h72] = 8'h00;
      run_op({i[3:0], 4'h7}, 16'h0300, 1'b0, 8'h72, 8'h00, 1'b0);
      zp[8'h40] = 8'hA5;
      run_op({i[3:0], 4'hF}, 16'h0400, 1'b0, 8'h40, 8'h10, 1'b0);
      zp[8'h40] = 8'h5A;
      run_op({i[3:0], 4'hF}, 16'h0400, 1'b0, 8'h40, 8'hF0, 1'b0);
      zp[8'h72] = 8'hFF;
      run_op({i[3:0], 4'h7}, 16'h0300, 1'b0, 8'h72, 8'h00, 1'b0);
    end
    // R3 example: clear bit 4 at 0x72
    zp[8'h72] = 8'hFF;
    run_op(8'h47, 16'h0500, 1'b0, 8'h72, 8'h00, 1'b0);
    chk(zp[8'h72] == 8'hEF, "R3 clear bit 4", 32'(zp[8'h72]), 32'hEF);
    // R6 page-crossing forward, backward, self loop, wrap
    zp[8'h10] = 8'h01;
    run_op(8'h8F, 16'h12FD, 1'b0, 8'h10, 8'h7F, 1'b0);
    run_op(8'h8F, 16'h2005, 1'b0, 8'h10, 8'h80, 1'b0);
    run_op(8'h8F, 16'h3000, 1'b0, 8'h10, 8'hFD, 1'b0);
    run_op(8'h8F, 16'hFFF0, 1'b0, 8'h10, 8'h7F, 1'b0);
    // R8 legacy on all 32 bit opcodes
    for (int i = 0; i < 32; i++)
      run_op({i[4:1], i[0] ? 4'hF : 4'h7}, 16'h0600, 1'b1, 8'h33, 8'h05, 1'b0);
    // R9 other opcodes
    run_op(8'hEA, 16'h0700, 1'b0, 8'h33, 8'h00, 1'b0);
    run_op(8'h03, 16'hFFFD, 1'b0, 8'h33, 8'h00, 1'b0);
    // R10 start pulse mid-instruction
    run_op(8'h27, 16'h0800, 1'b0, 8'h44, 8'h00, 1'b1);
    run_op(8'hBF, 16'h0900, 1'b0, 8'h45, 8'hC0, 1'b1);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  op = 8'($urandom);
      logic [15:0] pc = 16'h0100 + 16'($urandom % 32'hFEFD);
      if ($urandom % 4 != 0) op[3:0] = ($urandom % 2) ? 4'hF : 4'h7;
      run_op(op, pc, ($urandom % 8) == 0, 8'($urandom), 8'($urandom),
             ($urandom % 6) == 0);
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule